// File: doc/BRIEF.md
# SDRAM Single-Burst Write Sequencer

This block turns one user write request into the command sequence that a single-data-rate SDRAM expects. The request carries a bank, a row, a column and four data words. The sequencer opens the row, waits the row-to-column delay, and issues a write with auto-precharge disabled. It streams the four words on consecutive clocks and waits out write recovery. It then closes the bank with a single-bank precharge and waits the precharge time before it opens another row.

All timing is counted in clock cycles. The write-recovery wait is derived at elaboration from a time in picoseconds and the clock period, rounded up. A single row-age counter also holds back the precharge until the row-active minimum has passed. It holds back the next activate until the row-cycle minimum has passed as well. When both sides allow it, a request held valid gets back-to-back transactions at the tightest legal spacing.

Parameter limits: `T_RCD` ≥ 2, derived write recovery ≥ 2, `T_RP` ≥ 3, and `T_RC` greater than `T_RAS`.

Top module: `sdram_wr_seq`

## Requirements
- R1: Commands appear on {cs_n, ras_n, cas_n, we_n} as ACTIVE = 0011, WRITE = 0100, PRECHARGE = 0010 and NOP = 0111. Clock enable is always 1. After reset the outputs show NOP, ready = 1, dq_oe = 0 and dqm = all ones.
- R2: ready is 1 only while the block is idle. A request seen with req_valid = 1 and ready = 1 at a rising edge produces ACTIVE on the next cycle, with the row zero-extended on sd_addr and the bank on sd_ba.
- R3: The request fields and req_valid are ignored while ready = 0. WRITE, data and PRECHARGE use the values latched at acceptance, and no ACTIVE is issued before the block returns to idle.
- R4: WRITE comes exactly T_RCD cycles after ACTIVE, with the same bank. The column is on sd_addr[9:0] and sd_addr[12:10] = 0, so bit 10 low disables auto-precharge.
- R5: The four words go out on the WRITE cycle and the three following cycles, req_data[15:0] first and then in ascending order. sd_dq_oe = 1 and sd_dqm = 00 in exactly those four cycles; elsewhere sd_dq_oe = 0 and sd_dqm = 11.
- R6: PRECHARGE uses the same bank with sd_addr = 0, so bit 10 low selects single-bank scope. It comes max(T_RCD + 3 + ceil(T_WR_PS / CLK_PERIOD_PS), T_RAS) cycles after ACTIVE.
- R7: The next ACTIVE comes no sooner than max(PRECHARGE + T_RP, previous ACTIVE + T_RC). ready rises exactly one cycle before that point, so a request held valid is opened at that exact cycle.
- R8: Every cycle of a transaction that carries none of the commands above shows NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_data | input | 4*DATA_W | Four burst words, word 0 in the low bits |
| ready | output | 1 | Idle and able to accept a request |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| sd_dq | output | DATA_W | Write data |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dqm | output | DATA_W/8 | Byte masks, high = masked |

## Verification
The hardest situation to reach is a stretched wait, where the row-active or row-cycle minimum, not write recovery or precharge time, decides when a command may go out. With realistic values these minimums are covered by the other delays. The bench therefore runs a second instance with a short row-to-column delay and long row windows. In that instance both the PRECHARGE and the following ACTIVE must be held back. Requests are kept valid across the ready edge, so each gap is seen at its exact minimum rather than padded by idle cycles.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sd_cmd_e;

  // each state names what the registered outputs show in that cycle
  typedef enum logic [2:0] {
    S_IDLE,
    S_ACT,
    S_RCD,
    S_WR,
    S_BURST,
    S_REC,
    S_PRE,
    S_RP
  } seq_state_e;

  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_phase_ctr.sv
module sdram_phase_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count <= '0;
    end else if (count != {W{1'b1}}) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sdram_row_guard.sv
module sdram_row_guard #(
  parameter int T_RAS = 7,
  parameter int T_RC  = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        act_go,
  output logic [$clog2(T_RC+1)-1:0]   age,
  output logic                        ras_ready,
  output logic                        rc_ready
);

  localparam int AGE_W = $clog2(T_RC + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= AGE_W'(T_RC);
    end else if (act_go) begin
      age <= '0;
    end else if (int'(age) < T_RC) begin
      age <= age + 1'b1;
    end
  end

  // next cycle may carry PRECHARGE / next-but-one may carry ACTIVE
  assign ras_ready = int'(age) >= T_RAS - 1;
  assign rc_ready  = int'(age) >= T_RC - 2;

  // R7: an ACTIVE is only scheduled once the row cycle has elapsed
  p_act_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    act_go |-> int'(age) >= T_RC - 1);

endmodule

// File: rtl/sdram_burst_buf.sv
module sdram_burst_buf #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [WORDS*DATA_W-1:0]   load_words,
  input  logic                      shift,
  output logic [DATA_W-1:0]         head
);

  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    if (i == WORDS - 1) begin : g_last
      always_ff @(posedge clk) begin
        if (rst)        word_q[i] <= '0;
        else if (load)  word_q[i] <= load_words[i*DATA_W +: DATA_W];
        else if (shift) word_q[i] <= '0;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)        word_q[i] <= '0;
        else if (load)  word_q[i] <= load_words[i*DATA_W +: DATA_W];
        else if (shift) word_q[i] <= word_q[i+1];
      end
    end
  end

  assign head = word_q[0];

  // R5: a new request is never loaded while a burst is being streamed
  p_load_not_shift_r5: assert property (@(posedge clk) disable iff (rst)
    load |-> !shift);

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
  import sdram_wr_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ROW_W         = 13,
  parameter int COL_W         = 10,
  parameter int BANK_W        = 2,
  parameter int ADDR_W        = 13,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int T_WR_PS       = 15000,
  parameter int T_RCD         = 3,
  parameter int T_RAS         = 7,
  parameter int T_RP          = 3,
  parameter int T_RC          = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [COL_W-1:0]     req_col,
  input  logic [4*DATA_W-1:0]  req_data,
  output logic                 ready,
  output logic                 sd_cke,
  output logic                 sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [BANK_W-1:0]    sd_ba,
  output logic [ADDR_W-1:0]    sd_addr,
  output logic [DATA_W-1:0]    sd_dq,
  output logic                 sd_dq_oe,
  output logic [DATA_W/8-1:0]  sd_dqm
);

  localparam int BURST_LEN = 4;
  localparam int T_WR      = cyc_ceil(T_WR_PS, CLK_PERIOD_PS);
  localparam int DQM_W     = DATA_W / 8;
  localparam int PH_MAX    = imax(imax(T_RCD, T_WR), T_RP) + BURST_LEN;
  localparam int PH_W      = $clog2(PH_MAX + 1);
  localparam int AGE_W     = $clog2(T_RC + 1);

  seq_state_e          state_q, nxt;
  sd_cmd_e             cmd_q;
  logic [PH_W-1:0]     ph_q;
  logic [AGE_W-1:0]    age;
  logic                ras_ready, rc_ready;
  logic [BANK_W-1:0]   bank_q;
  logic [COL_W-1:0]    col_q;
  logic [ADDR_W-1:0]   row_ext, col_ext;
  logic [DATA_W-1:0]   buf_head;
  logic                accept, shift;

  assign accept = (state_q == S_IDLE) && req_valid;
  assign shift  = (nxt == S_WR) || (nxt == S_BURST);

  // next-state: what the outputs will show in the following cycle
  always_comb begin
    nxt = state_q;
    unique case (state_q)
      S_IDLE:  if (req_valid) nxt = S_ACT;
      S_ACT:   nxt = S_RCD;
      S_RCD:   if (int'(ph_q) >= T_RCD - 2) nxt = S_WR;
      S_WR:    nxt = S_BURST;
      S_BURST: if (int'(ph_q) >= BURST_LEN - 2) nxt = S_REC;
      S_REC:   if (int'(ph_q) >= T_WR - 2 && ras_ready) nxt = S_PRE;
      S_PRE:   nxt = S_RP;
      S_RP:    if (int'(ph_q) >= T_RP - 3 && rc_ready) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    row_ext = '0;
    row_ext[ROW_W-1:0] = req_row;
    col_ext = '0;
    col_ext[COL_W-1:0] = col_q;
  end

  sdram_phase_ctr #(.W(PH_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .restart (nxt != state_q),
    .count   (ph_q)
  );

  sdram_row_guard #(.T_RAS(T_RAS), .T_RC(T_RC)) u_guard (
    .clk       (clk),
    .rst       (rst),
    .act_go    (nxt == S_ACT),
    .age       (age),
    .ras_ready (ras_ready),
    .rc_ready  (rc_ready)
  );

  sdram_burst_buf #(.DATA_W(DATA_W), .WORDS(BURST_LEN)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_words (req_data),
    .shift      (shift),
    .head       (buf_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      col_q  <= '0;
    end else if (accept) begin
      bank_q <= req_bank;
      col_q  <= req_col;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      ready    <= 1'b1;
      cmd_q    <= CMD_NOP;
      sd_ba    <= '0;
      sd_addr  <= '0;
      sd_dq    <= '0;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= {DQM_W{1'b1}};
    end else begin
      state_q  <= nxt;
      ready    <= (nxt == S_IDLE);
      sd_dq_oe <= shift;
      sd_dqm   <= shift ? {DQM_W{1'b0}} : {DQM_W{1'b1}};
      sd_dq    <= shift ? buf_head : '0;
      unique case (nxt)
        S_ACT: begin
          cmd_q   <= CMD_ACT;
          sd_ba   <= req_bank;
          sd_addr <= row_ext;
        end
        S_WR: begin
          cmd_q   <= CMD_WR;
          sd_ba   <= bank_q;
          sd_addr <= col_ext;
        end
        S_PRE: begin
          cmd_q   <= CMD_PRE;
          sd_ba   <= bank_q;
          sd_addr <= '0;
        end
        default: begin
          cmd_q   <= CMD_NOP;
          sd_ba   <= '0;
          sd_addr <= '0;
        end
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke = 1'b1;

  // R2: ready only while idle, and idle shows NOP
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
    ready |-> cmd_q == CMD_NOP && !sd_dq_oe);

  // R3: latched bank does not move during a transaction
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {S_WR, S_BURST, S_REC, S_PRE, S_RP}) |-> $stable(bank_q));

  // R4: WRITE lands exactly T_RCD after ACTIVE, auto-precharge off
  p_wr_at_rcd_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_q == CMD_WR |-> int'(age) == T_RCD && !sd_addr[10]);

  // R5: data lanes are unmasked whenever data is driven
  p_mask_open_r5: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |-> sd_dqm == '0);

  // R6: PRECHARGE honours row-active minimum, single-bank scope
  p_pre_after_ras_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_q == CMD_PRE |-> int'(age) >= T_RAS && !sd_addr[10]);

  // R6: no data is driven on the precharge cycle
  p_pre_no_data_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_q == CMD_PRE |-> !sd_dq_oe);

endmodule

// File: tb/test_sdram_wr_seq.sv
module test_sdram_wr_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [63:0] req_data = '0;
  logic        sel = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // instance A: defaults; instance B: long row windows
  logic        a_rdy, a_cke, a_cs, a_ras, a_cas, a_we, a_oe;
  logic [1:0]  a_ba, a_dqm;
  logic [12:0] a_addr;
  logic [15:0] a_dq;
  logic        b_rdy, b_cke, b_cs, b_ras, b_cas, b_we, b_oe;
  logic [1:0]  b_ba, b_dqm;
  logic [12:0] b_addr;
  logic [15:0] b_dq;

  sdram_wr_seq i_sdram_wr_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid & ~sel),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_data(req_data),
    .ready(a_rdy), .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
    .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_ba(a_ba), .sd_addr(a_addr),
    .sd_dq(a_dq), .sd_dq_oe(a_oe), .sd_dqm(a_dqm));

  sdram_wr_seq #(.CLK_PERIOD_PS(7500), .T_WR_PS(14000), .T_RCD(2),
                 .T_RAS(11), .T_RP(3), .T_RC(16)) i_sdram_wr_seq_slow (
    .clk(clk), .rst(rst), .req_valid(req_valid & sel),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_data(req_data),
    .ready(b_rdy), .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
    .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_ba(b_ba), .sd_addr(b_addr),
    .sd_dq(b_dq), .sd_dq_oe(b_oe), .sd_dqm(b_dqm));

  logic        m_rdy, m_cke, m_oe;
  logic [3:0]  m_cmd;
  logic [1:0]  m_ba, m_dqm;
  logic [12:0] m_addr;
  logic [15:0] m_dq;
  assign m_rdy  = sel ? b_rdy : a_rdy;
  assign m_cke  = sel ? b_cke : a_cke;
  assign m_oe   = sel ? b_oe : a_oe;
  assign m_cmd  = sel ? {b_cs, b_ras, b_cas, b_we} : {a_cs, a_ras, a_cas, a_we};
  assign m_ba   = sel ? b_ba : a_ba;
  assign m_dqm  = sel ? b_dqm : a_dqm;
  assign m_addr = sel ? b_addr : a_addr;
  assign m_dq   = sel ? b_dq : a_dq;

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, WR = 4'b0100, PRE = 4'b0010;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction
  function automatic int t_rcd(); return sel ? 2 : 3; endfunction
  function automatic int t_wr();  return sel ? ceil_div(14000, 7500) : ceil_div(15000, 4000); endfunction
  function automatic int pre_at(); return mx(t_rcd() + 3 + t_wr(), sel ? 11 : 7); endfunction
  function automatic int act_next(); return mx(pre_at() + 3, sel ? 16 : 10); endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (inst %0d)", tag, act, exp, sel);
    end
  endtask

  // called at a negedge with ready high; returns at the negedge where ready is high again
  task automatic run_txn(input logic [1:0] bk, input logic [12:0] rw, input logic [9:0] cl,
                         input logic [63:0] dat);
    int rcd = t_rcd();
    int p   = pre_at();
    int a   = act_next();
    req_bank = bk; req_row = rw; req_col = cl; req_data = dat; req_valid = 1'b1;
    @(posedge clk);
    for (int i = 0; i < a; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(m_cmd == ACT, "R2 ACTIVE after accept", m_cmd, ACT);
        chk(m_addr == rw && m_ba == bk, "R2 row/bank", {m_ba, m_addr}, {bk, rw});
      end else if (i == rcd) begin
        chk(m_cmd == WR, "R4 WRITE at T_RCD", m_cmd, WR);
        chk(m_addr == {3'b000, cl} && m_ba == bk, "R3 R4 latched column/bank, A10 low",
            {m_ba, m_addr}, {bk, 3'b000, cl});
      end else if (i == p) begin
        chk(m_cmd == PRE, "R6 PRECHARGE timing", m_cmd, PRE);
        chk(m_addr == 13'd0 && m_ba == bk, "R6 single bank", {m_ba, m_addr}, {bk, 13'd0});
      end else begin
        chk(m_cmd == NOP, "R8 R3 NOP between commands", m_cmd, NOP);
      end
      if (i >= rcd && i < rcd + 4) begin
        chk(m_oe && m_dqm == 2'b00 && m_dq == dat[(i-rcd)*16 +: 16], "R5 burst word",
            {m_oe, m_dqm, m_dq}, {1'b1, 2'b00, dat[(i-rcd)*16 +: 16]});
      end else begin
        chk(!m_oe && m_dqm == 2'b11, "R5 bus quiet", {m_oe, m_dqm}, {1'b0, 2'b11});
      end
      chk(m_rdy == (i == a - 1), "R7 ready timing", m_rdy, (i == a - 1));
      chk(m_cke, "R1 cke", m_cke, 1);
      if (i == 0) begin
        // fields change while busy: must be ignored
        req_bank = ~bk; req_col = ~cl; req_row = ~rw; req_data = ~dat;
      end
      if (i == a - 1) req_valid = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(m_rdy && m_cmd == NOP && !m_oe, "R2 idle holds", {m_rdy, m_cmd}, {1'b1, NOP});
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int seed = $urandom(2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      @(negedge clk);
      chk(m_cmd == NOP && m_rdy && !m_oe && m_dqm == 2'b11 && m_cke, "R1 reset state",
          {m_cmd, m_rdy, m_oe, m_dqm}, {NOP, 1'b1, 1'b0, 2'b11});
    end
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      idle(2);
      // directed corners: extremes, then back-to-back (R7 exact spacing)
      run_txn(2'd3, 13'h1FFF, 10'h3FF, 64'hFFFF_0000_FFFF_0000);
      run_txn(2'd0, 13'h0000, 10'h000, 64'h0000_FFFF_0000_FFFF);
      run_txn(2'd1, 13'h0ABC, 10'h155, 64'h4444_3333_2222_1111);
      idle(1);
      for (int t = 0; t < 25; t++) begin
        run_txn(2'($urandom), 13'($urandom), 10'($urandom),
                {$urandom, $urandom});
        idle(int'($urandom % 3));
      end
    end
    if (seed == 0) checks = checks;
    report();
  end

endmodule